// File: doc/BRIEF.md
# Power-Management Event Controller

This block is a small power-management register file reached through a 64-byte I/O window. It keeps a 16-bit event status register, a 16-bit event enable register, a 16-bit control register and a free-running up-counter used as the power-management timer. Three external event lines (power button, real-time-clock alarm, global lock release) and the timer's most-significant-bit transition set status bits. Software clears a status bit by writing a one to it.

The system-control interrupt output is level sensitive: it stays high for as long as any of the four defined status bits is set together with its enable bit. The window's base address and its on/off switch come from configuration inputs that a host bridge drives: a base dword and an enable byte. The window is closed while bit 0 of the enable byte is clear, which is also its state after reset.

Top module: `pm_evt_sci_ctrl`

## Requirements
- R1: After reset the status, enable and control registers read 0, the timer starts from 0 and `sci` is low.
- R2: An access hits the window when `cfg_en[0]` is 1 and `io_addr[15:6]` equals `cfg_base[15:6]`. The other base bits are ignored. Accesses outside the window read 0 and do not write anything.
- R3: While `cfg_en[0]` is 0, every read returns 0 and every write is ignored.
- R4: Register offsets inside the window are: status 0x00, enable 0x02, control 0x04, timer 0x08. Any other offset reads 0. `io_rdata` is registered: it carries the selected value on the clock edge where `io_rd` is sampled high, and it is 0 after any edge where `io_rd` is low.
- R5: Status bit positions are: timer 0, global lock 5, power button 8, RTC alarm 10. A rising edge on `evt_pwrbtn`, `evt_rtc` or `evt_glbl` sets its bit. An input that is held high does not set the bit again after it has been cleared.
- R6: A write to the status register clears each bit written as 1. If an event sets a bit on the same edge that a write clears it, the bit stays set.
- R7: The enable register keeps only bits 0, 5, 8 and 10. The other bits read 0.
- R8: The control register stores and returns all 16 written bits.
- R9: The timer is a TMR_W-bit counter that increments on every clock and wraps. A read returns it zero-extended.
- R10: The timer status bit is set when the counter's top bit changes value, and only if enable bit 0 is 1 at that edge.
- R11: `sci` is high exactly when some bit in {0,5,8,10} is set in both the status and enable registers. It follows them in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 32 | Configuration base dword; bits 15:6 place the window |
| cfg_en | input | 8 | Configuration enable byte; bit 0 opens the window |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 32 | Write data; bits 15:0 used |
| io_rdata | output | 32 | Registered read data |
| evt_pwrbtn | input | 1 | Power-button event line |
| evt_rtc | input | 1 | RTC alarm event line |
| evt_glbl | input | 1 | Global-lock event line |
| sci | output | 1 | Level-sensitive system-control interrupt |

## Verification
The bench drives inputs and samples outputs on the falling clock edge. Read data appears after the rising edge that samples `io_rd`, so each read task samples at the next falling edge. A write or an event edge changes status on the rising edge that samples it, and `sci` follows with no further register. The `sci` checks are therefore taken at the falling edge right after the write or event. Timer events are checked after waits longer than a full half-period of the counter's top bit.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
   // register width and status bit positions
   localparam int REG_W      = 16;
   localparam int BIT_TMR    = 0;
   localparam int BIT_GLBL   = 5;
   localparam int BIT_PWRBTN = 8;
   localparam int BIT_RTC    = 10;
   localparam int N_EVT      = 3;

   localparam logic [REG_W-1:0] EVT_MASK =
      REG_W'((1 << BIT_TMR) | (1 << BIT_GLBL) | (1 << BIT_PWRBTN) | (1 << BIT_RTC));

   // byte offsets inside the window
   localparam int OFS_STS = 'h00;
   localparam int OFS_EN  = 'h02;
   localparam int OFS_CTL = 'h04;
   localparam int OFS_TMR = 'h08;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STS,
      SEL_EN,
      SEL_CTL,
      SEL_TMR
   } reg_sel_e;

   // external event index -> status bit position
   function automatic int evt_pos(input int idx);
      case (idx)
         0:       return BIT_PWRBTN;
         1:       return BIT_RTC;
         default: return BIT_GLBL;
      endcase
   endfunction
endpackage

// File: rtl/pm_win_decode.sv
module pm_win_decode
   import pm_evt_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int WIN_LG2 = 6
) (
   input  logic [ADDR_W-1:WIN_LG2] base_hi,
   input  logic                    win_on,
   input  logic [ADDR_W-1:0]       addr,
   output logic                    hit,
   output reg_sel_e                sel
);
   logic [WIN_LG2-1:0] ofs;

   assign ofs = addr[WIN_LG2-1:0];
   assign hit = win_on && (addr[ADDR_W-1:WIN_LG2] == base_hi);

   always_comb begin
      if      (ofs == WIN_LG2'(OFS_STS)) sel = SEL_STS;
      else if (ofs == WIN_LG2'(OFS_EN))  sel = SEL_EN;
      else if (ofs == WIN_LG2'(OFS_CTL)) sel = SEL_CTL;
      else if (ofs == WIN_LG2'(OFS_TMR)) sel = SEL_TMR;
      else                               sel = SEL_NONE;
   end
endmodule

// File: rtl/pm_timer.sv
module pm_timer #(
   parameter int TMR_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [TMR_W-1:0] cnt,
   output logic             msb_flip
);
   logic [TMR_W-1:0] cnt_q;
   logic [TMR_W-1:0] cnt_nxt;

   assign cnt_nxt  = cnt_q + TMR_W'(1);
   assign msb_flip = cnt_nxt[TMR_W-1] ^ cnt_q[TMR_W-1];
   assign cnt      = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end
endmodule

// File: rtl/pm_evt_status.sv
module pm_evt_status
   import pm_evt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt_in,
   input  logic             tmr_flip,
   input  logic             wr_sts,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] sts_q,
   output logic [REG_W-1:0] en_q
);
   logic [N_EVT-1:0] evt_rise;
   logic [REG_W-1:0] set_vec;
   logic [REG_W-1:0] clr_vec;

   for (genvar g = 0; g < N_EVT; g++) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= evt_in[g];
      end
      assign evt_rise[g] = evt_in[g] & ~prev_q;
   end

   always_comb begin
      set_vec = '0;
      for (int i = 0; i < N_EVT; i++) begin
         if (evt_rise[i]) set_vec[evt_pos(i)] = 1'b1;
      end
      // timer event armed only while its enable is set
      if (tmr_flip && en_q[BIT_TMR]) set_vec[BIT_TMR] = 1'b1;
   end

   assign clr_vec = wr_sts ? (wdata & EVT_MASK) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q <= '0;
         en_q  <= '0;
      end else begin
         sts_q <= (sts_q & ~clr_vec) | set_vec;
         if (wr_en) en_q <= wdata & EVT_MASK;
      end
   end
endmodule

// File: rtl/pm_evt_sci_ctrl.sv
module pm_evt_sci_ctrl
   import pm_evt_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 32,
   parameter int CFG_W    = 32,
   parameter int CFG_EN_W = 8,
   parameter int WIN_LG2  = 6,
   parameter int TMR_W    = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CFG_W-1:0]    cfg_base,
   input  logic [CFG_EN_W-1:0] cfg_en,
   input  logic [ADDR_W-1:0]   io_addr,
   input  logic                io_wr,
   input  logic                io_rd,
   input  logic [DATA_W-1:0]   io_wdata,
   output logic [DATA_W-1:0]   io_rdata,
   input  logic                evt_pwrbtn,
   input  logic                evt_rtc,
   input  logic                evt_glbl,
   output logic                sci
);
   // elaboration-time parameter checks
   if (TMR_W < 2 || TMR_W > DATA_W) begin : g_bad_tmr
      $error("TMR_W must be in 2..DATA_W");
   end
   if (DATA_W <= REG_W) begin : g_bad_data
      $error("DATA_W must exceed the register width");
   end
   if (WIN_LG2 < 4 || ADDR_W <= WIN_LG2) begin : g_bad_win
      $error("window must hold offset 0x08 and fit the address");
   end
   if (CFG_W <= ADDR_W || CFG_EN_W < 2) begin : g_bad_cfg
      $error("configuration inputs too narrow");
   end

   logic             hit;
   reg_sel_e         sel;
   logic             wr_sts, wr_en, wr_ctl;
   logic [REG_W-1:0] sts_q, en_q, ctl_q;
   logic [TMR_W-1:0] tmr_cnt;
   logic             tmr_flip;
   logic             unused_bits;

   assign unused_bits = ^{cfg_base[CFG_W-1:ADDR_W], cfg_base[WIN_LG2-1:0],
                          cfg_en[CFG_EN_W-1:1], io_wdata[DATA_W-1:REG_W]};

   pm_win_decode #(.ADDR_W(ADDR_W), .WIN_LG2(WIN_LG2)) u_dec (
      .base_hi (cfg_base[ADDR_W-1:WIN_LG2]),
      .win_on  (cfg_en[0]),
      .addr    (io_addr),
      .hit     (hit),
      .sel     (sel)
   );

   assign wr_sts = io_wr && hit && (sel == SEL_STS);
   assign wr_en  = io_wr && hit && (sel == SEL_EN);
   assign wr_ctl = io_wr && hit && (sel == SEL_CTL);

   pm_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (tmr_cnt),
      .msb_flip (tmr_flip)
   );

   pm_evt_status u_sts (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_in   ({evt_glbl, evt_rtc, evt_pwrbtn}),
      .tmr_flip (tmr_flip),
      .wr_sts   (wr_sts),
      .wr_en    (wr_en),
      .wdata    (io_wdata[REG_W-1:0]),
      .sts_q    (sts_q),
      .en_q     (en_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (wr_ctl) ctl_q <= io_wdata[REG_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         io_rdata <= '0;
      end else if (io_rd && hit) begin
         case (sel)
            SEL_STS: io_rdata <= DATA_W'(sts_q);
            SEL_EN:  io_rdata <= DATA_W'(en_q);
            SEL_CTL: io_rdata <= DATA_W'(ctl_q);
            SEL_TMR: io_rdata <= DATA_W'(tmr_cnt);
            default: io_rdata <= '0;
         endcase
      end else begin
         io_rdata <= '0;
      end
   end

   // level interrupt from the four defined enabled events
   assign sci = |(sts_q & en_q & EVT_MASK);
endmodule

// File: rtl/pm_evt_sci_chk.sv
module pm_evt_sci_chk
   import pm_evt_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int TMR_W  = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              win_on,
   input logic              io_rd,
   input logic [DATA_W-1:0] io_rdata,
   input logic [REG_W-1:0]  wdata,
   input logic              wr_sts,
   input logic              evt_pwrbtn,
   input logic              evt_glbl,
   input logic [REG_W-1:0]  sts_q,
   input logic [REG_W-1:0]  en_q,
   input logic [TMR_W-1:0]  tmr_cnt,
   input logic              sci
);
   // R3
   closed_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_on && io_rd) |=> (io_rdata == '0));

   // R4
   idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |=> (io_rdata == '0));

   // R5
   pwrbtn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $rose(evt_pwrbtn)) |=> sts_q[BIT_PWRBTN]);

   // R6
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && wr_sts && wdata[BIT_GLBL] && !$rose(evt_glbl))
      |=> !sts_q[BIT_GLBL]);

   // R9
   tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (tmr_cnt == TMR_W'($past(tmr_cnt) + TMR_W'(1))));

   // R10
   tmr_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[BIT_TMR] && !sts_q[BIT_TMR]) |=> !sts_q[BIT_TMR]);

   // R11
   sci_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> !sci);
endmodule

bind pm_evt_sci_ctrl pm_evt_sci_chk #(.DATA_W(DATA_W), .TMR_W(TMR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .win_on     (cfg_en[0]),
   .io_rd      (io_rd),
   .io_rdata   (io_rdata),
   .wdata      (io_wdata[15:0]),
   .wr_sts     (wr_sts),
   .evt_pwrbtn (evt_pwrbtn),
   .evt_glbl   (evt_glbl),
   .sts_q      (sts_q),
   .en_q       (en_q),
   .tmr_cnt    (tmr_cnt),
   .sci        (sci)
);

// File: tb/test_pm_evt_sci_ctrl.sv
module test_pm_evt_sci_ctrl;
   localparam int TB_TMR_W = 10;
   localparam logic [15:0] BASE = 16'hA5C0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_base = 32'h1234_A5C7;
   logic [7:0]  cfg_en = 8'h00;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [31:0] io_wdata = '0;
   logic [31:0] io_rdata;
   logic        evt_pwrbtn = 1'b0;
   logic        evt_rtc = 1'b0;
   logic        evt_glbl = 1'b0;
   logic        sci;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pm_evt_sci_ctrl #(.TMR_W(TB_TMR_W)) i_pm_evt_sci_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_en(cfg_en),
      .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
      .io_rdata(io_rdata), .evt_pwrbtn(evt_pwrbtn), .evt_rtc(evt_rtc),
      .evt_glbl(evt_glbl), .sci(sci)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // all tasks are entered and left at a falling edge
   task automatic io_write(input logic [15:0] a, input logic [31:0] d);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic io_read(input logic [15:0] a, output logic [31:0] d);
      io_addr = a; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
      d = io_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      cfg_en = 8'h01;
      io_read(BASE + 16'h00, d); check("R1 status", d, 32'h0);
      io_read(BASE + 16'h02, d); check("R1 enable", d, 32'h0);
      io_read(BASE + 16'h04, d); check("R1 control", d, 32'h0);
      check("R1 sci", {31'b0, sci}, 32'h0);
   endtask

   task automatic t_window();
      logic [31:0] d;
      io_write(BASE + 16'h04, 32'hFFFF_BEEF);
      io_read(BASE + 16'h04, d);  check("R8 control readback", d, 32'h0000_BEEF);
      @(negedge clk);
      check("R4 rdata idle", io_rdata, 32'h0);
      io_read(BASE + 16'h0C, d);  check("R4 unmapped offset", d, 32'h0);
      io_read(BASE + 16'h44, d);  check("R2 outside read", d, 32'h0);
      io_write(BASE + 16'h44, 32'h2222);
      io_read(BASE + 16'h04, d);  check("R2 outside write ignored", d, 32'h0000_BEEF);
      cfg_en = 8'hFE;
      io_read(BASE + 16'h04, d);  check("R3 closed read", d, 32'h0);
      io_write(BASE + 16'h04, 32'h1111);
      cfg_en = 8'h01;
      io_read(BASE + 16'h04, d);  check("R3 closed write ignored", d, 32'h0000_BEEF);
   endtask

   task automatic t_enable();
      logic [31:0] d;
      io_write(BASE + 16'h02, 32'h0000_FFFF);
      io_read(BASE + 16'h02, d);  check("R7 enable mask", d, 32'h0000_0521);
      io_write(BASE + 16'h02, 32'h0);
   endtask

   task automatic t_events();
      logic [31:0] d;
      evt_pwrbtn = 1'b1; @(negedge clk); evt_pwrbtn = 1'b0;
      io_read(BASE, d);           check("R5 power button bit 8", d, 32'h0100);
      check("R11 sci off without enable", {31'b0, sci}, 32'h0);
      io_write(BASE + 16'h02, 32'h0100);
      check("R11 sci on with enable", {31'b0, sci}, 32'h1);
      io_write(BASE, 32'h0100);
      check("R11 sci drops on clear", {31'b0, sci}, 32'h0);
      io_read(BASE, d);           check("R6 w1c clear", d, 32'h0);
      evt_glbl = 1'b1; @(negedge clk);
      io_read(BASE, d);           check("R5 global lock bit 5", d, 32'h0020);
      io_write(BASE, 32'h0020);
      @(negedge clk);
      io_read(BASE, d);           check("R5 held level no re-set", d, 32'h0);
      evt_glbl = 1'b0;
      evt_rtc = 1'b1;
      io_write(BASE, 32'h0400);
      io_read(BASE, d);           check("R6 set wins over clear", d, 32'h0400);
      io_write(BASE, 32'h0001);
      io_read(BASE, d);           check("R6 other bit clear keeps RTC bit 10", d, 32'h0400);
      io_write(BASE + 16'h02, 32'h0400);
      check("R11 sci from RTC", {31'b0, sci}, 32'h1);
      evt_rtc = 1'b0;
      io_write(BASE, 32'hFFFF);
      io_write(BASE + 16'h02, 32'h0);
      io_read(BASE, d);           check("R6 clear all", d, 32'h0);
   endtask

   task automatic t_timer();
      logic [31:0] a, b;
      io_read(BASE + 16'h08, a);
      io_read(BASE + 16'h08, b);
      check("R9 timer step", (b - a) & 32'h3FF, 32'h1);
      check("R9 timer zero-extended", b >> TB_TMR_W, 32'h0);
      repeat (1100) @(negedge clk);
      io_read(BASE, a);           check("R10 no timer status while disabled", a, 32'h0);
      io_write(BASE + 16'h02, 32'h0001);
      repeat (1100) @(negedge clk);
      io_read(BASE, a);           check("R10 timer status bit 0", a, 32'h0001);
      check("R11 sci from timer", {31'b0, sci}, 32'h1);
      io_write(BASE + 16'h02, 32'h0);
      io_write(BASE, 32'h0001);
      io_read(BASE, a);           check("R10 timer status cleared", a, 32'h0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_window();
      t_enable();
      t_events();
      t_timer();
      finish_run();
   end

   initial begin
      #1_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule